// File: doc/BRIEF.md
# Serial EEPROM Page Write Collector and Program Sequencer

This block sits behind the bus protocol engine of a small serial EEPROM. A write transfer opens with a word-address strobe. Each data byte that follows is held in a page buffer, in a slot chosen by the low bits of the address. The upper address bits stay fixed for the whole transfer. When the protocol engine reports STOP, the block runs a self-timed programming cycle. The cycle copies the buffered bytes, lowest slot first, into a byte-wide memory array model. Each byte takes one programming tick of `TICK_DIV` clock cycles.

Two parameters set the overflow behaviour. With `OVF_WRAP` = 0, the page holds exactly `PAGE_BYTES` bytes. One more data byte is refused and the whole transfer is abandoned. With `OVF_WRAP` = 1, extra bytes wrap around the page and overwrite earlier slots. The write-protect input is sampled at STOP. While it is high, buffered bytes whose address falls in [`PROT_LO`, `PROT_HI`] are dropped. The remaining bytes are still programmed, and only the bytes actually written add to the cycle length. While programming is in progress, `busy_o` is high and every byte strobe is refused.

Every byte strobe gets an answer one cycle later: `ack_vld_o` marks the answer and `ack_o` says whether the byte was accepted. A combinational read port exposes the array contents.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, `busy_o` and `ack_vld_o` are low and every array byte reads 0xFF.
- R2: A word-address strobe while idle is accepted and opens a write transfer. A data byte strobe with no open transfer is refused.
- R3: Accepted data bytes are programmed at {upper bits of the word address, slot}. The slot starts at the low log2(`PAGE_BYTES`) address bits and increments modulo `PAGE_BYTES` per byte. A single byte followed by STOP programs just that byte.
- R4: With `OVF_WRAP` = 0, the data byte after `PAGE_BYTES` accepted bytes is refused. Every later byte of that transfer is also refused, and the following STOP programs nothing.
- R5: With `OVF_WRAP` = 1, bytes beyond `PAGE_BYTES` are accepted and overwrite the slot that the wrapped pointer selects. The last byte written to a slot is the one programmed.
- R6: `busy_o` rises in the cycle after the STOP strobe. It stays high for exactly N×`TICK_DIV` cycles, where N is the number of bytes actually written.
- R7: While `busy_o` is high, every byte strobe is answered with `ack_o` low and opens no transfer.
- R8: When `wp_i` is high at STOP, bytes addressed in [`PROT_LO`, `PROT_HI`] are not written. Bytes outside that range are written as usual.
- R9: A STOP with zero writable buffered bytes leaves `busy_o` low.
- R10: `ack_vld_o` is high only in the single cycle that follows a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect, sampled at STOP |
| addr_load_i | input | 1 | Word-address byte strobe |
| addr_i | input | ADDR_W | Word address carried with the strobe |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | STOP seen on the bus |
| rd_addr_i | input | ADDR_W | Array read address |
| busy_o | output | 1 | Programming cycle in progress |
| ack_vld_o | output | 1 | Byte answer valid |
| ack_o | output | 1 | Byte accepted (1) or refused (0) |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The assertions watch several rules on every clock cycle:
- any strobe while busy is refused;
- an answer never appears without a strobe in the cycle before;
- the accepted-byte count never exceeds the page in the no-wrap variant;
- the tick counter stays in range and busy always has work left;
- no write ever reaches the protected range while protection was latched.

Only the bench scenarios can show the rest. These are the exact busy length per byte count, the slot order and the wrap overwrite, abandoning a transfer after an overflow, and the array contents that each mix of protection and address produces.

// File: rtl/eeprom_pp_pkg.sv
package eeprom_pp_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/eeprom_pp_buf.sv
module eeprom_pp_buf #(
  parameter int unsigned PAGE_BYTES = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          OVF_WRAP   = 1'b0,
  localparam int unsigned SLOT_W    = $clog2(PAGE_BYTES),
  localparam int unsigned HI_W      = ADDR_W - SLOT_W,
  localparam int unsigned CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              open_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              data_valid_i,
  input  logic [7:0]                        data_i,
  input  logic                              clear_i,
  output logic                              acc_o,
  output logic                              armed_o,
  output logic [HI_W-1:0]                   base_hi_o,
  output logic [PAGE_BYTES-1:0]             slot_vld_o,
  output logic [PAGE_BYTES-1:0][7:0]        slot_data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);

  logic                       active_q, abort_q;
  logic [SLOT_W-1:0]          ptr_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [HI_W-1:0]            base_q;
  logic [PAGE_BYTES-1:0]      vld_q;
  logic [PAGE_BYTES-1:0][7:0] slot_q;
  logic full, room, live, take, overflow;

  assign full = (cnt_q == CNT_FULL);

  // overflow policy picked by parameter
  if (OVF_WRAP) begin : g_wrap
    assign room = 1'b1;
  end else begin : g_abort
    assign room = !full;
  end

  assign live     = data_valid_i && active_q && !abort_q;
  assign take     = live && room;
  assign overflow = live && !room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      abort_q  <= 1'b0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
      vld_q    <= '0;
      slot_q   <= '0;
    end else if (open_i) begin
      active_q <= 1'b1;
      abort_q  <= 1'b0;
      ptr_q    <= addr_i[SLOT_W-1:0];
      base_q   <= addr_i[ADDR_W-1:SLOT_W];
      cnt_q    <= '0;
      vld_q    <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      abort_q  <= 1'b0;
      vld_q    <= '0;
    end else begin
      if (take) begin
        slot_q[ptr_q] <= data_i;
        vld_q[ptr_q]  <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
      if (overflow) abort_q <= 1'b1;
    end
  end

  assign acc_o       = take;
  assign armed_o     = active_q && !abort_q;
  assign base_hi_o   = base_q;
  assign slot_vld_o  = vld_q;
  assign slot_data_o = slot_q;

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  a_r4_no_take_aborted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> !acc_o);
endmodule

// File: rtl/eeprom_pp_seq.sv
module eeprom_pp_seq
  import eeprom_pp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TICK_DIV   = 100000,
  parameter int unsigned PROT_LO    = 'h80,
  parameter int unsigned PROT_HI    = 'hFF,
  localparam int unsigned SLOT_W    = $clog2(PAGE_BYTES),
  localparam int unsigned HI_W      = ADDR_W - SLOT_W,
  localparam int unsigned TW        = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        wp_i,
  input  logic [HI_W-1:0]             base_hi_i,
  input  logic [PAGE_BYTES-1:0]       vld_i,
  input  logic [PAGE_BYTES-1:0][7:0]  slot_data_i,
  output logic                        busy_o,
  output logic                        we_o,
  output logic [ADDR_W-1:0]           waddr_o,
  output logic [7:0]                  wdata_o
);
  localparam logic [ADDR_W-1:0] P_LO   = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] P_HI   = ADDR_W'(PROT_HI);
  localparam logic [TW-1:0]     T_LAST = TW'(TICK_DIV - 1);

  seq_state_e              state_q;
  logic [PAGE_BYTES-1:0]   mask_q, ok_d, rest;
  logic [TW-1:0]           tmr_q;
  logic [SLOT_W-1:0]       cur;
  logic                    wp_q, tick;

  // bytes that may be written under the protection level seen at STOP
  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
    logic [ADDR_W-1:0] a;
    assign a       = {base_hi_i, SLOT_W'(k)};
    assign ok_d[k] = vld_i[k] && !(wp_i && a >= P_LO && a <= P_HI);
  end

  always_comb begin
    cur = '0;
    for (int k = PAGE_BYTES - 1; k >= 0; k--)
      if (mask_q[k]) cur = SLOT_W'(k);
  end

  assign tick = (state_q == SEQ_PROG) && (tmr_q == T_LAST);
  assign rest = mask_q & ~(PAGE_BYTES'(1) << cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      mask_q  <= '0;
      tmr_q   <= '0;
      wp_q    <= 1'b0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i && (ok_d != '0)) begin
        state_q <= SEQ_PROG;
        mask_q  <= ok_d;
        tmr_q   <= '0;
        wp_q    <= wp_i;
      end
    end else if (tick) begin
      tmr_q  <= '0;
      mask_q <= rest;
      if (rest == '0) state_q <= SEQ_IDLE;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign busy_o  = (state_q == SEQ_PROG);
  assign we_o    = tick;
  assign waddr_o = {base_hi_i, cur};
  assign wdata_o = slot_data_i[cur];

  a_r6_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= T_LAST);
  a_r6_busy_has_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mask_q != '0));
  a_r8_no_protected_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && wp_q) |-> !(waddr_o >= P_LO && waddr_o <= P_HI));
endmodule

// File: rtl/eeprom_pp_array.sv
module eeprom_pp_array #(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog #(
  parameter int unsigned PAGE_BYTES = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          OVF_WRAP   = 1'b0,
  parameter int unsigned TICK_DIV   = 100000,
  parameter int unsigned PROT_LO    = 'h80,
  parameter int unsigned PROT_HI    = 'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              busy_o,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned SLOT_W = $clog2(PAGE_BYTES);
  localparam int unsigned HI_W   = ADDR_W - SLOT_W;

  logic                       busy, open, dv, stop_ok, acc, armed, we;
  logic [HI_W-1:0]            base_hi;
  logic [PAGE_BYTES-1:0]      vld;
  logic [PAGE_BYTES-1:0][7:0] sdata;
  logic [ADDR_W-1:0]          waddr;
  logic [7:0]                 wdata;
  logic                       ack_vld_q, ack_q;

  assign open    = addr_load_i && !busy;
  assign dv      = data_valid_i && !busy;
  assign stop_ok = stop_i && !busy;

  eeprom_pp_buf #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .OVF_WRAP(OVF_WRAP)
  ) u_buf (
    .clk_i, .rst_ni,
    .open_i(open), .addr_i, .data_valid_i(dv), .data_i,
    .clear_i(stop_ok), .acc_o(acc), .armed_o(armed),
    .base_hi_o(base_hi), .slot_vld_o(vld), .slot_data_o(sdata)
  );

  eeprom_pp_seq #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(stop_ok && armed), .wp_i, .base_hi_i(base_hi),
    .vld_i(vld), .slot_data_i(sdata),
    .busy_o(busy), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  eeprom_pp_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_vld_q <= addr_load_i || data_valid_i;
      ack_q     <= open || acc;
    end
  end

  assign busy_o    = busy;
  assign ack_vld_o = ack_vld_q;
  assign ack_o     = ack_q;

  a_r7_nack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (addr_load_i || data_valid_i)) |=> (ack_vld_o && !ack_o));
  a_r10_ack_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(addr_load_i || data_valid_i));
  a_r9_empty_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !armed) |=> !busy_o);
  a_r10_ack_implies_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_vld_o);
endmodule

// File: tb/sim_eeprom_page_prog.sv
module sim_eeprom_page_prog;
  localparam int D = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wp [2], al [2], dv [2], st [2];
  logic [8:0] ad [2], ra [2];
  logic [7:0] dd [2], rdd [2];
  logic       busy [2], av [2], ak [2];

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit [7:0] ref_mem [2][512];

  always #4 clk = ~clk;

  eeprom_page_prog #(
    .PAGE_BYTES(2), .ADDR_W(8), .OVF_WRAP(1'b0), .TICK_DIV(D),
    .PROT_LO('h80), .PROT_HI('hFF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp[0]), .addr_load_i(al[0]),
    .addr_i(ad[0][7:0]), .data_valid_i(dv[0]), .data_i(dd[0]), .stop_i(st[0]),
    .rd_addr_i(ra[0][7:0]), .busy_o(busy[0]), .ack_vld_o(av[0]), .ack_o(ak[0]),
    .rd_data_o(rdd[0])
  );

  eeprom_page_prog #(
    .PAGE_BYTES(8), .ADDR_W(9), .OVF_WRAP(1'b1), .TICK_DIV(D),
    .PROT_LO('h100), .PROT_HI('h1FF)
  ) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp[1]), .addr_load_i(al[1]),
    .addr_i(ad[1]), .data_valid_i(dv[1]), .data_i(dd[1]), .stop_i(st[1]),
    .rd_addr_i(ra[1]), .busy_o(busy[1]), .ack_vld_o(av[1]), .ack_o(ak[1]),
    .rd_data_o(rdd[1])
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit prot(int u, int a);
    return u ? (a >= 'h100 && a <= 'h1FF) : (a >= 'h80 && a <= 'hFF);
  endfunction

  task automatic strobe(int u, bit is_addr, int a, bit [7:0] d, bit exp, string req);
    @(negedge clk);
    al[u] = is_addr; dv[u] = !is_addr; ad[u] = 9'(a); dd[u] = d;
    @(negedge clk);
    al[u] = 0; dv[u] = 0;
    chk(av[u] == 1'b1, req, "ack valid", int'(av[u]), 1);
    chk(ak[u] == exp, req, "ack", int'(ak[u]), int'(exp));
  endtask

  task automatic rd_chk(int u, int a, string req);
    ra[u] = 9'(a);
    #1;
    chk(rdd[u] == ref_mem[u][a], req, $sformatf("mem[%0h]", a), int'(rdd[u]), int'(ref_mem[u][a]));
  endtask

  task automatic do_xfer(int u, int addr, int n, bit wpv, bit probe);
    int P = u ? 8 : 2;
    bit [7:0] sd [8];
    bit sv [8];
    int ptr = addr % P;
    int base = addr - ptr;
    bit ab = 0;
    int nw = 0, cnt = 0, exp_cyc;
    string rq;
    for (int k = 0; k < 8; k++) begin sd[k] = 0; sv[k] = 0; end
    strobe(u, 1, addr, 0, 1, "R2");
    for (int j = 0; j < n; j++) begin
      bit [7:0] b = 8'($urandom);
      if (ab || (u == 0 && j >= P)) begin
        ab = 1;
        strobe(u, 0, 0, b, 0, "R4");
      end else begin
        strobe(u, 0, 0, b, 1, (j >= P) ? "R5" : "R3");
        sd[ptr] = b; sv[ptr] = 1; ptr = (ptr + 1) % P;
      end
    end
    wp[u] = wpv;
    @(negedge clk); st[u] = 1;
    @(negedge clk); st[u] = 0;
    if (!ab)
      for (int k = 0; k < P; k++)
        if (sv[k] && !(wpv && prot(u, base + k))) nw++;
    exp_cyc = ab ? 0 : nw * D;
    while (busy[u] && cnt < 1000) begin
      cnt++;
      if (probe && cnt == 2) begin al[u] = 1; ad[u] = 9'(addr); end
      if (probe && cnt == 3) begin
        al[u] = 0;
        chk(av[u] && !ak[u], "R7", "strobe while busy", int'(ak[u]), 0);
      end
      @(negedge clk);
    end
    rq = ab ? "R4" : (nw == 0 ? "R9" : "R6");
    chk(cnt == exp_cyc, rq, "busy cycles", cnt, exp_cyc);
    if (!ab)
      for (int k = 0; k < P; k++)
        if (sv[k] && !(wpv && prot(u, base + k))) ref_mem[u][base + k] = sd[k];
    for (int k = 0; k < P; k++)
      rd_chk(u, base + k, wpv ? "R8" : (u ? "R5" : "R3"));
    if (probe) strobe(u, 0, 0, 8'h5A, 0, "R7");
    wp[u] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    for (int u = 0; u < 2; u++) begin
      wp[u] = 0; al[u] = 0; dv[u] = 0; st[u] = 0; ad[u] = 0; dd[u] = 0; ra[u] = 0;
      for (int a = 0; a < 512; a++) ref_mem[u][a] = 8'hFF;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(!busy[u], "R1", "busy after reset", int'(busy[u]), 0);
      chk(!av[u], "R1", "ack_vld after reset", int'(av[u]), 0);
      rd_chk(u, 'h00, "R1");
      rd_chk(u, 'h80, "R1");
    end
    // data byte with no open transfer
    strobe(0, 0, 0, 8'h11, 0, "R2");
    @(negedge clk);
    chk(!av[0], "R10", "ack_vld one cycle only", int'(av[0]), 0);
    do_xfer(0, 'h10, 1, 0, 0);      // R3 single byte
    do_xfer(0, 'h21, 2, 0, 0);      // R3 slot wrap inside page
    do_xfer(0, 'h40, 3, 0, 0);      // R4 overflow abort
    do_xfer(0, 'h42, 4, 0, 0);      // R4 further bytes refused
    do_xfer(1, 'h1F5, 11, 0, 0);    // R5 wrap overwrite
    do_xfer(1, 'h0C3, 3, 0, 0);     // R3 on 8-byte page
    do_xfer(0, 'hA0, 2, 1, 0);      // R8 fully protected, R9 no cycle
    do_xfer(0, 'h30, 2, 1, 0);      // R8 unprotected while wp high
    do_xfer(1, 'h1F0, 3, 1, 0);     // R8
    do_xfer(1, 'h0F0, 3, 1, 0);     // R8
    do_xfer(0, 'h50, 0, 0, 0);      // R9 empty stop
    do_xfer(1, 'h60, 0, 0, 0);      // R9
    do_xfer(0, 'h70, 2, 0, 1);      // R7 probe during busy
    do_xfer(1, 'h188, 5, 0, 1);     // R7
    for (int i = 0; i < 40; i++) begin
      int u = int'($urandom % 2);
      int a = int'($urandom % (u ? 512 : 256));
      int n = int'($urandom % (u ? 12 : 4));
      do_xfer(u, a, n, bit'($urandom % 2), 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule